// File: doc/BRIEF.md
# Inter-Core Doorbell Mailbox

This block lets any core of a multi-core cluster interrupt any other core and pass it a 16-bit message. Every core owns two 32-bit words on a simple word-addressed slave bus: a write-only command word and a read-only inbox word. A core writes its own command word with a send request, a target core number and a payload. The target's inbox then latches the sender's number and the payload, sets a pending flag and raises that core's level interrupt.

The receiving core reads its inbox to learn who called and why. It then writes its own command word with the acknowledge flag to drop the interrupt. The sender's identity is taken from which command word was written, so the bus needs no master ID. There are no interrupt inputs, and all traffic arrives through bus writes. Reads are combinational from the registers. Writes take effect at the rising clock edge where `bus_we` is high.

Top module: `ipi_mailbox`

## Requirements
- R1: The word address 2·c selects the command word of core c, which is byte offset c·8. The word address 2·c+1 selects its inbox word, which is byte offset c·8+4. An inbox read returns bit 31 = 0, bit 30 = pending, bits 29..16 = source core number and bits 15..0 = payload.
- R2: A write to core S's command word with bit 30 (send) set, target D in bits 29..16 and payload X in bits 15..0 gives core D's inbox pending=1, source=S and payload=X from the next cycle on.
- R3: `irq_out[c]` is high exactly while core c's pending flag is set.
- R4: A write to core c's own command word with bit 31 (acknowledge) set clears c's pending flag from the next cycle. `irq_out[c]` then reads 0. Source and payload are kept.
- R5: A send whose target number is NUM_CORES or greater changes no inbox and no interrupt.
- R6: A send to a core whose pending flag is already set overwrites source and payload with the newer message, and pending stays 1.
- R7: A single write with both acknowledge and send set applies the acknowledge first and the delivery second. A core that sends to itself this way ends with pending=1.
- R8: Reading a command word returns 0. Addresses at or above 2·NUM_CORES read 0, and writes to them change nothing.
- R9: With `rst` high at a rising edge, all pending flags, source fields, payload fields and interrupts clear to 0.
- R10: A bus cycle with `bus_we` low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq_out | output | NUM_CORES | Level interrupt per core |

## Verification
The bench overwrites a pending message from a second sender. A design that dropped the newer message would still report the old source and payload. It combines acknowledge and send in one self-addressed write, where the wrong ordering leaves the core with no pending interrupt. It sends to a target one past the last core and writes a command one window past the top of the map. A decoder that truncated either index would wrongly interrupt core 0 or core 1. It also reads command words, where leaked data would show up, and drives a full send with `bus_we` low to catch an ungated write path.

// File: rtl/ipi_mbox_pkg.sv
package ipi_mbox_pkg;

    localparam int CORE_FIELD_W = 14;
    localparam int MSG_W        = 16;

    typedef struct packed {
        logic                    ack;
        logic                    send;
        logic [CORE_FIELD_W-1:0] target;
        logic [MSG_W-1:0]        msg;
    } cmd_word_t;

    typedef struct packed {
        logic                    rsvd;
        logic                    pend;
        logic [CORE_FIELD_W-1:0] src;
        logic [MSG_W-1:0]        msg;
    } inbox_word_t;

    function automatic inbox_word_t fresh_inbox(input logic [CORE_FIELD_W-1:0] s,
                                                input logic [MSG_W-1:0] m);
        inbox_word_t w;
        w.rsvd = 1'b0;
        w.pend = 1'b1;
        w.src  = s;
        w.msg  = m;
        return w;
    endfunction

endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
    import ipi_mbox_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [31:0]             wdata,
    output logic [NUM_CORES-1:0]    ack_vec,
    output logic [NUM_CORES-1:0]    dlv_vec,
    output logic [CORE_FIELD_W-1:0] sender,
    output logic [MSG_W-1:0]        payload
);
    localparam int SEL_W = ADDR_W - 1;
    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(2 * NUM_CORES);

    cmd_word_t        cw;
    logic [SEL_W-1:0] core_sel;
    logic             hit_cmd;

    assign cw       = cmd_word_t'(wdata);
    assign core_sel = addr[ADDR_W-1:1];
    assign hit_cmd  = we && (addr < TOP_ADDR) && !addr[0];
    assign sender   = CORE_FIELD_W'(core_sel);
    assign payload  = cw.msg;

    always_comb begin
        for (int c = 0; c < NUM_CORES; c++) begin
            ack_vec[c] = hit_cmd && cw.ack  && (core_sel == SEL_W'(c));
            dlv_vec[c] = hit_cmd && cw.send && (cw.target == CORE_FIELD_W'(c));
        end
    end

    // R1/R4: a single command word selects at most one acknowledging core
    p_single_ack_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_vec));
    // R5: out-of-range targets deliver nowhere
    p_no_stray_target_r5: assert property (@(posedge clk) disable iff (rst)
        (cw.target >= CORE_FIELD_W'(NUM_CORES)) |-> (dlv_vec == '0));
    // R8, R10: no strobes without an in-range write
    p_idle_bus_r10: assert property (@(posedge clk) disable iff (rst)
        (!we || addr >= TOP_ADDR) |-> (ack_vec == '0 && dlv_vec == '0));

endmodule

// File: rtl/ipi_inbox_slot.sv
module ipi_inbox_slot
    import ipi_mbox_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ack,
    input  logic                    dlv,
    input  logic [CORE_FIELD_W-1:0] sender,
    input  logic [MSG_W-1:0]        payload,
    output inbox_word_t             inbox,
    output logic                    irq
);
    inbox_word_t box_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            box_q <= '0;
        end else if (dlv) begin
            // R7: delivery wins over a same-cycle acknowledge
            box_q <= fresh_inbox(sender, payload);
        end else if (ack) begin
            box_q.pend <= 1'b0;
        end
    end

    assign inbox = box_q;
    assign irq   = box_q.pend;

    p_deliver_latch_r2: assert property (@(posedge clk) disable iff (rst)
        dlv |=> (inbox.pend && inbox.src == $past(sender) && inbox.msg == $past(payload)));
    p_ack_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (ack && !dlv) |=> !irq);
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!ack && !dlv) |=> $stable(inbox));
    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (rst)
        !inbox.rsvd);

endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
    import ipi_mbox_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_CORES-1:0] irq_out
);
    localparam int SEL_W = ADDR_W - 1;
    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(2 * NUM_CORES);

    logic [NUM_CORES-1:0]    ack_vec;
    logic [NUM_CORES-1:0]    dlv_vec;
    logic [CORE_FIELD_W-1:0] sender;
    logic [MSG_W-1:0]        payload;
    inbox_word_t             inbox [NUM_CORES];

    ipi_cmd_decode #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_decode (
        .clk     (clk),
        .rst     (rst),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .ack_vec (ack_vec),
        .dlv_vec (dlv_vec),
        .sender  (sender),
        .payload (payload)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_slot
        ipi_inbox_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .ack     (ack_vec[c]),
            .dlv     (dlv_vec[c]),
            .sender  (sender),
            .payload (payload),
            .inbox   (inbox[c]),
            .irq     (irq_out[c])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr < TOP_ADDR && bus_addr[0]) begin
            for (int c = 0; c < NUM_CORES; c++) begin
                if (bus_addr[ADDR_W-1:1] == SEL_W'(c)) bus_rdata = inbox[c];
            end
        end
    end

    // R8: command words always read as zero
    p_cmd_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (!bus_addr[0] || bus_addr >= TOP_ADDR) |-> (bus_rdata == '0));
    // R1: reserved bit never reads back as one
    p_rdata_rsvd_r1: assert property (@(posedge clk) disable iff (rst)
        !bus_rdata[31]);

endmodule

// File: tb/ipi_mailbox_test.sv
module ipi_mailbox_test;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int AW = 6;

    typedef struct packed {
        logic [AW-1:0] waddr;
        logic [31:0]   wdata;
        logic [AW-1:0] raddr;
        logic [31:0]   exp_rd;
        logic [NC-1:0] exp_irq;
    } vec_t;

    // Command word: bit31 ack, bit30 send, 29..16 target, 15..0 payload
    localparam vec_t VECS [0:8] = '{
        '{6'd2, 32'h4003_BEEF, 6'd7, 32'h4001_BEEF, 4'b1000}, // R2 R1 R3: core1 -> core3
        '{6'd0, 32'h4002_1234, 6'd5, 32'h4000_1234, 4'b1100}, // R2: core0 -> core2
        '{6'd4, 32'h4003_0055, 6'd7, 32'h4002_0055, 4'b1100}, // R6: overwrite at core3
        '{6'd6, 32'h8000_0000, 6'd7, 32'h0002_0055, 4'b0100}, // R4: core3 acks
        '{6'd0, 32'h4004_AAAA, 6'd1, 32'h0000_0000, 4'b0100}, // R5: target 4 ignored
        '{6'd4, 32'hC002_0707, 6'd5, 32'h4002_0707, 4'b0100}, // R7: ack+self send
        '{6'd8, 32'h4001_0001, 6'd3, 32'h0000_0000, 4'b0100}, // R8: write past map
        '{6'd2, 32'h8000_0000, 6'd4, 32'h0000_0000, 4'b0100}, // R8: command reads 0
        '{6'd6, 32'h4000_FFFF, 6'd1, 32'h4003_FFFF, 4'b0101}  // R2: core3 -> core0
    };

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] bus_addr;
    logic          bus_we;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic [NC-1:0] irq_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipi_mailbox #(.NUM_CORES(NC), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d, input logic we);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = we;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic read_at(input logic [AW-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        logic [31:0] rd;
        rst = 1'b1; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: reset state
        check32("R9 irq after reset", 32'(irq_out), 32'h0);
        for (int c = 0; c < NC; c++) begin
            read_at(AW'(2*c + 1), rd);
            check32("R9 inbox after reset", rd, 32'h0);
        end

        for (int i = 0; i < 9; i++) begin
            bus_write(VECS[i].waddr, VECS[i].wdata, 1'b1);
            read_at(VECS[i].raddr, rd);
            check32($sformatf("vector %0d rdata", i), rd, VECS[i].exp_rd);
            check32($sformatf("vector %0d irq", i), 32'(irq_out), 32'(VECS[i].exp_irq));
        end

        // R10: full send with write strobe low
        bus_write(6'd2, 32'h4000_0001, 1'b0);
        read_at(6'd1, rd);
        check32("R10 inbox unchanged", rd, 32'h4003_FFFF);
        check32("R10 irq unchanged", 32'(irq_out), 32'h5);

        // R5: largest target number
        bus_write(6'd2, 32'h7FFF_1111, 1'b1);
        check32("R5 max target ignored", 32'(irq_out), 32'h5);

        // R8: top of address space reads zero
        read_at(6'd63, rd);
        check32("R8 high address read", rd, 32'h0);

        // R3: irq follows pending through ack of core0
        bus_write(6'd0, 32'h8000_0000, 1'b1);
        check32("R3 irq after core0 ack", 32'(irq_out), 32'h4);

        // R9: reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check32("R9 irq after late reset", 32'(irq_out), 32'h0);
        read_at(6'd5, rd);
        check32("R9 inbox after late reset", rd, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule